// File: doc/BRIEF.md
# DCO Digital Loop Filter

This block closes the digital half of a frequency-locking loop around a digitally controlled oscillator (DCO). It holds a 12-bit control word. The upper 4 bits select the oscillator's divider, and the lower 8 bits select its delay stages. An external frequency comparator measures a low-rate base clock against its nominal rate. On each comparison it reports one of six error bands, together with a single-cycle valid strobe. For each strobe the filter applies one signed, band-dependent correction to the whole 12-bit word:

- Subtracting from the word speeds the oscillator up.
- Adding to the word slows it down.

The correction sizes are nonlinear. A fine step of 1 is used close to nominal, a step of 8 in the middle bands, and a coarse step of 32 far from nominal. As a result, lock is reached quickly and then held with little jitter. The word is treated as a single binary number, so a carry or borrow out of the stage field moves the divider field.

The arithmetic wraps modulo 4096. In extreme conditions the word can therefore leave its usable span of 0x000 to 0x9FF and land at divider codes 0xA to 0xF. Those codes are presented to the oscillator as divider 9, the slowest setting. The stored word itself is left untouched. The loop recovers by normal subtraction steps only. A registered stable flag reports that the last valid comparison fell in one of the two fine bands, which means the error is within ±5 percent.

Top module: `dco_loop_filter`

## Requirements
- R1: While `rst_n` is low, the control word is forced to the parameter `RESET_WORD` (default 0x800) and `stable` is cleared. After reset, `div_out` therefore shows 8 and `stg_out` shows 0x00.
- R2: On a clock edge with `band_vld` high, these band codes lower the 12-bit word: code 0 (base far below nominal) subtracts 32, code 1 subtracts 8, and code 2 subtracts 1. The new value appears on the outputs after that edge.
- R3: On a clock edge with `band_vld` high, these band codes raise the 12-bit word: code 3 adds 1, code 4 adds 8, and code 5 (base far above nominal) adds 32.
- R4: A carry out of the 8-bit stage field increments the divider field. For example, 0x7FF plus 1 gives divider 8 and stage 0x00.
- R5: A borrow out of the stage field decrements the divider field. For example, 0x800 minus 1 gives divider 7 and stage 0xFF.
- R6: The word and `stable` do not change on cycles where `band_vld` is low, and they do not change for band codes 6 and 7.
- R7: `div_out` never exceeds 9. A stored divider field of 0xA to 0xF is shown as 9, while `stg_out` always shows the stored stage field unchanged.
- R8: The word wraps modulo 4096. 0x000 minus 1 becomes 0xFFF (shown as divider 9, stage 0xFF), and 0xFFF plus 1 becomes 0x000.
- R9: The stored word keeps divider codes above 9 and is not clamped. Starting from 0xB00, eight subtractions of 32 leave 0xA00, which shows divider 9 and stage 0x00.
- R10: On each valid strobe, `stable` is set for band codes 2 and 3 and cleared for band codes 0, 1, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| band_vld | input | 1 | One-cycle strobe marking a new comparator result |
| band_code | input | 3 | Error band: 0..2 base slow (far to near), 3..5 base fast (near to far), 6..7 unused |
| div_out | output | 4 | Divider selection to the DCO, clamped to 9 |
| stg_out | output | 8 | Stage selection to the DCO |
| stable | output | 1 | Last valid comparison was within ±5 percent of nominal |

## Verification
A corrupted control word shows up on `div_out`/`stg_out` in the same cycle, because both outputs come straight from the register through only the clamp. A wrong carry or borrow shows as a divider jump that appears one edge after the strobe that crossed the stage boundary. A word wrongly clamped in storage stays invisible while the divider reads 9. It only appears many strobes later, when the loop descends out of the 0xA to 0xF region earlier than the stored value allows. A wrong stable flag is visible one edge after the strobe that should have set or cleared it.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

  // Comparator error bands, ordered from base-clock-slowest to fastest.
  typedef enum logic [2:0] {
    BAND_SLOW_FAR  = 3'd0,
    BAND_SLOW_MID  = 3'd1,
    BAND_SLOW_NEAR = 3'd2,
    BAND_FAST_NEAR = 3'd3,
    BAND_FAST_MID  = 3'd4,
    BAND_FAST_FAR  = 3'd5
  } band_e;

  localparam int unsigned BAND_W = 3;

endpackage

// File: rtl/dlf_step_map.sv
module dlf_step_map
  import dlf_pkg::*;
#(
  parameter int unsigned WORD_W     = 12,
  parameter int unsigned STEP_FINE  = 1,
  parameter int unsigned STEP_MID   = 8,
  parameter int unsigned STEP_COARSE = 32
) (
  input  logic              vld_i,
  input  logic [BAND_W-1:0] code_i,
  output logic              upd_o,
  output logic              dec_o,
  output logic [WORD_W-1:0] mag_o,
  output logic              fine_o
);

  localparam logic [WORD_W-1:0] MagFine   = WORD_W'(STEP_FINE);
  localparam logic [WORD_W-1:0] MagMid    = WORD_W'(STEP_MID);
  localparam logic [WORD_W-1:0] MagCoarse = WORD_W'(STEP_COARSE);

  always_comb begin
    upd_o  = 1'b0;
    dec_o  = 1'b0;
    mag_o  = '0;
    fine_o = 1'b0;
    if (vld_i) begin
      unique case (code_i)
        BAND_SLOW_FAR:  begin upd_o = 1'b1; dec_o = 1'b1; mag_o = MagCoarse; end
        BAND_SLOW_MID:  begin upd_o = 1'b1; dec_o = 1'b1; mag_o = MagMid;    end
        BAND_SLOW_NEAR: begin upd_o = 1'b1; dec_o = 1'b1; mag_o = MagFine; fine_o = 1'b1; end
        BAND_FAST_NEAR: begin upd_o = 1'b1; dec_o = 1'b0; mag_o = MagFine; fine_o = 1'b1; end
        BAND_FAST_MID:  begin upd_o = 1'b1; dec_o = 1'b0; mag_o = MagMid;    end
        BAND_FAST_FAR:  begin upd_o = 1'b1; dec_o = 1'b0; mag_o = MagCoarse; end
        default:        begin upd_o = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/dlf_word_reg.sv
module dlf_word_reg #(
  parameter int unsigned   WORD_W     = 12,
  parameter logic [11:0]   RESET_WORD = 12'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic              dec_i,
  input  logic [WORD_W-1:0] mag_i,
  input  logic              fine_i,
  output logic [WORD_W-1:0] word_o,
  output logic              stable_o
);

  localparam logic [WORD_W-1:0] WordInit = WORD_W'(RESET_WORD);

  logic [WORD_W-1:0] word_q, word_d;
  logic              stable_q, stable_d;

  // Next state: full-width add/subtract, wrapping modulo 2**WORD_W.
  always_comb begin
    word_d   = dec_i ? (word_q - mag_i) : (word_q + mag_i);
    stable_d = fine_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= WordInit;
      stable_q <= 1'b0;
    end else if (upd_i) begin
      word_q   <= word_d;
      stable_q <= stable_d;
    end
  end

  assign word_o   = word_q;
  assign stable_o = stable_q;

endmodule

// File: rtl/dlf_div_clamp.sv
module dlf_div_clamp #(
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DIV_MAX = 9
) (
  input  logic [DIV_W-1:0] raw_i,
  output logic [DIV_W-1:0] div_o
);

  localparam logic [DIV_W-1:0] Ceil = DIV_W'(DIV_MAX);

  always_comb begin
    div_o = (raw_i > Ceil) ? Ceil : raw_i;
  end

endmodule

// File: rtl/dco_loop_filter.sv
module dco_loop_filter
  import dlf_pkg::*;
#(
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned STG_W       = 8,
  parameter int unsigned DIV_MAX     = 9,
  parameter logic [11:0] RESET_WORD  = 12'h800,
  parameter int unsigned STEP_FINE   = 1,
  parameter int unsigned STEP_MID    = 8,
  parameter int unsigned STEP_COARSE = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             band_vld,
  input  logic [2:0]       band_code,
  output logic [DIV_W-1:0] div_out,
  output logic [STG_W-1:0] stg_out,
  output logic             stable
);

  localparam int unsigned WORD_W = DIV_W + STG_W;

  logic              upd, dec, fine;
  logic [WORD_W-1:0] mag;
  logic [WORD_W-1:0] word;

  dlf_step_map #(
    .WORD_W     (WORD_W),
    .STEP_FINE  (STEP_FINE),
    .STEP_MID   (STEP_MID),
    .STEP_COARSE(STEP_COARSE)
  ) u_map (
    .vld_i (band_vld),
    .code_i(band_code),
    .upd_o (upd),
    .dec_o (dec),
    .mag_o (mag),
    .fine_o(fine)
  );

  dlf_word_reg #(
    .WORD_W    (WORD_W),
    .RESET_WORD(RESET_WORD)
  ) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (upd),
    .dec_i   (dec),
    .mag_i   (mag),
    .fine_i  (fine),
    .word_o  (word),
    .stable_o(stable)
  );

  dlf_div_clamp #(
    .DIV_W  (DIV_W),
    .DIV_MAX(DIV_MAX)
  ) u_clamp (
    .raw_i(word[WORD_W-1:STG_W]),
    .div_o(div_out)
  );

  assign stg_out = word[STG_W-1:0];

endmodule

// File: rtl/dco_loop_filter_chk.sv
module dco_loop_filter_chk #(
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned STG_W   = 8,
  parameter int unsigned DIV_MAX = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             band_vld,
  input logic [2:0]       band_code,
  input logic [DIV_W-1:0] div_out,
  input logic [STG_W-1:0] stg_out,
  input logic             stable
);

  logic act;
  assign act = band_vld && (band_code <= 3'd5);

  p_div_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_out <= DIV_W'(DIV_MAX));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> ($stable(div_out) && $stable(stg_out) && $stable(stable)));

  p_fine_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (band_vld && (band_code == 3'd2 || band_code == 3'd3)) |=> stable);

  p_coarse_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act && band_code != 3'd2 && band_code != 3'd3) |=> !stable);

  p_fine_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (band_vld && band_code == 3'd3) |=> stg_out == $past(stg_out) + STG_W'(1));

  p_fine_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (band_vld && band_code == 3'd2) |=> stg_out == $past(stg_out) - STG_W'(1));

  p_coarse_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (band_vld && (band_code == 3'd0 || band_code == 3'd5)) |=> $stable(stg_out[4:0]));

endmodule

bind dco_loop_filter dco_loop_filter_chk #(
  .DIV_W  (DIV_W),
  .STG_W  (STG_W),
  .DIV_MAX(DIV_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .band_vld (band_vld),
  .band_code(band_code),
  .div_out  (div_out),
  .stg_out  (stg_out),
  .stable   (stable)
);

// File: tb/sim_dco_loop_filter.sv
module sim_dco_loop_filter;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       band_vld;
  logic [2:0] band_code;
  logic [3:0] div_out;
  logic [7:0] stg_out;
  logic       stable;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [11:0] exp_word;
  logic        exp_stable;

  dco_loop_filter u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .band_vld (band_vld),
    .band_code(band_code),
    .div_out  (div_out),
    .stg_out  (stg_out),
    .stable   (stable)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] shown_div(input logic [3:0] raw);
    return (raw > 4'd9) ? 4'd9 : raw;
  endfunction

  task automatic check(input string tag);
    logic [3:0] ed;
    ed = shown_div(exp_word[11:8]);
    n_checks++;
    if (div_out !== ed || stg_out !== exp_word[7:0] || stable !== exp_stable) begin
      n_fail++;
      $display("FAIL %s: got div=%h stg=%h stable=%b, expected div=%h stg=%h stable=%b",
               tag, div_out, stg_out, stable, ed, exp_word[7:0], exp_stable);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    band_vld = 1'b0;
    band_code = 3'd0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_word = 12'h800;
    exp_stable = 1'b0;
  endtask

  // One comparator strobe; updates the bench model from the band table.
  task automatic strobe(input logic [2:0] code, input string tag, input bit chk);
    @(negedge clk);
    band_vld = 1'b1;
    band_code = code;
    @(negedge clk);
    band_vld = 1'b0;
    case (code)
      3'd0: begin exp_word = exp_word - 12'd32; exp_stable = 1'b0; end
      3'd1: begin exp_word = exp_word - 12'd8;  exp_stable = 1'b0; end
      3'd2: begin exp_word = exp_word - 12'd1;  exp_stable = 1'b1; end
      3'd3: begin exp_word = exp_word + 12'd1;  exp_stable = 1'b1; end
      3'd4: begin exp_word = exp_word + 12'd8;  exp_stable = 1'b0; end
      3'd5: begin exp_word = exp_word + 12'd32; exp_stable = 1'b0; end
      default: ;
    endcase
    if (chk) check(tag);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset state");
  endtask

  task automatic t_fine_steps();
    strobe(3'd3, "R3 +1 and R10 stable set", 1);
    strobe(3'd2, "R2 -1 and R10 stable set", 1);
  endtask

  task automatic t_borrow_and_down();
    strobe(3'd2, "R5 borrow 800-1", 1);
    strobe(3'd0, "R2 -32 and R10 clear", 1);
    strobe(3'd1, "R2 -8", 1);
  endtask

  task automatic t_up_and_carry();
    strobe(3'd5, "R3 +32", 1);
    strobe(3'd4, "R3 +8 and R10 clear", 1);
    strobe(3'd3, "R4 carry 7FF+1", 1);
  endtask

  task automatic t_ignore();
    strobe(3'd6, "R6 code 6 ignored", 1);
    strobe(3'd7, "R6 code 7 ignored", 1);
    @(negedge clk);
    band_code = 3'd0;
    repeat (3) @(negedge clk);
    check("R6 no strobe hold");
  endtask

  task automatic t_high_region();
    do_reset();
    for (int i = 0; i < 24; i++) strobe(3'd5, "R7", 0);
    check("R7 B00 shown as divider 9");
    for (int i = 0; i < 8; i++) strobe(3'd0, "R9", 0);
    check("R9 raw kept, A00 shows 9");
    strobe(3'd2, "R9 recovery 9FF", 1);
    strobe(3'd0, "R9 below 9FF", 1);
  endtask

  task automatic t_wrap_low();
    do_reset();
    for (int i = 0; i < 64; i++) strobe(3'd0, "R8", 0);
    check("R8 reach 000");
    strobe(3'd2, "R8 wrap 000-1 to FFF", 1);
    strobe(3'd3, "R8 wrap FFF+1 to 000", 1);
  endtask

  initial begin
    rst_n = 1'b0;
    band_vld = 1'b0;
    band_code = 3'd0;
    exp_word = 12'h800;
    exp_stable = 1'b0;
    t_reset();
    t_fine_steps();
    t_borrow_and_down();
    t_up_and_carry();
    t_ignore();
    t_high_region();
    t_wrap_low();
    t_reset();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule